// File: doc/BRIEF.md
# I2C Channel Selector Target

This block is an I2C target whose only content is a small select register. The register chooses which of eight downstream bus channels is connected to the upstream bus. The block turns that choice into eight digital enable lines. The pass switches, level shifting and pull-ups are outside it. The enable lines are meant to drive those switches.

The upstream SCL and SDA lines are synchronised to the block clock. Any pulse too short to be a real bus level is removed before the protocol engine sees it. The engine decodes START, STOP, the address byte and data bytes. It acknowledges only its own address. A written value is held pending and is applied when the STOP arrives. A read returns the register contents.

The block has two resets. The power-on reset `rst_ni` leaves channel 0 enabled, so devices on that channel can be reached at once. The active-low `bus_rst_ni` input frees a stuck bus: it returns the engine to idle, releases SDA and deselects every channel.

Top module: `i2c_chan_sel`

## Requirements
- R1: At most one bit of `chan_en_o` is high at any time. Register bit 3 is the enable and bits 2:0 are the channel index. With bit 3 set, `chan_en_o` is the one-hot code of the index; with bit 3 clear, `chan_en_o` is zero.
- R2: After `rst_ni` is released, `chan_en_o` is 8'h01 and a read returns 8'h08.
- R3: While `bus_rst_ni` is low, `chan_en_o` is zero and `sda_oe_o` is low, both without waiting for a clock. Any transfer in progress is abandoned, and the register reads 8'h00 afterwards.
- R4: A write to address {4'b1110, `addr_pins_i`} followed by a data byte stores the low four bits of that byte.
- R5: A read returns {4'b0000, register} in every byte for as long as the controller acknowledges, and it releases SDA after the controller sends a NACK.
- R6: On either line, a pulse lasting `SPIKE_CYC`-1 clocks or fewer has no effect on decoding.
- R7: A new selection appears on `chan_en_o` only at the STOP that ends the write. When a write carries several data bytes, only the last one is kept.
- R8: No other 7-bit address is acknowledged, and `sda_oe_o` stays low while the engine is idle.
- R9: `sda_oe_o` changes only while SCL is low, and never sooner than `HOLD_CYC` clocks after SCL falls, except when a START, a STOP or a reset releases it.
- R10: A START or STOP inside a byte abandons that byte. The next transfer is decoded normally, and the partial byte is never stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sampling clock |
| rst_ni | input | 1 | Power-on reset, active low, asynchronous |
| bus_rst_ni | input | 1 | Bus recovery reset, active low, asynchronous |
| scl_i | input | 1 | Upstream SCL level |
| sda_i | input | 1 | Upstream SDA level (wired bus) |
| sda_oe_o | output | 1 | Pull SDA low when high |
| addr_pins_i | input | 3 | Low three bits of the target address |
| chan_en_o | output | 8 | Downstream channel enables |

## Verification
The line filter and edge detection add a fixed latency. Each line takes two synchroniser clocks and then `SPIKE_CYC` clocks of agreement. One more clock passes before the STOP commit. So `chan_en_o` changes on the seventh rising edge after the bench drives the STOP, and the reference model in the bench applies its pending value on exactly that edge. The model and the design are compared a quarter period after every rising edge, away from the edge itself. Data and acknowledge bits are sampled in the middle of the SCL high phase, long after the hold delay. Each change of `sda_oe_o` is also timed against the last falling edge of SCL.

// File: rtl/i2c_chan_sel_pkg.sv
package i2c_chan_sel_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WDATA,
    ST_WACK,
    ST_RDATA,
    ST_RACK
  } eng_state_e;

  localparam int BYTE_W = 8;
  localparam int ADDR_W = 7;
endpackage

// File: rtl/i2c_line_filt.sv
module i2c_line_filt #(
  parameter int SPIKE_CYC = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  output logic line_o
);
  localparam int CW = (SPIKE_CYC > 1) ? $clog2(SPIKE_CYC) : 1;

  logic [1:0]    sync_q;
  logic [CW-1:0] cnt_q;
  logic          out_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= 2'b11;
      cnt_q  <= '0;
      out_q  <= 1'b1;
    end else begin
      sync_q <= {sync_q[0], line_i};
      if (sync_q[1] == out_q) begin
        cnt_q <= '0;
      end else if (cnt_q == CW'(SPIKE_CYC - 1)) begin
        out_q <= sync_q[1];
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign line_o = out_q;

  AST_FILT_SETTLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_q != $past(out_q)) |-> ($past(sync_q[1]) == out_q && $past(sync_q[1], 2) == out_q)) // R6
    else $error("filter output moved on a short pulse");
endmodule

// File: rtl/i2c_sel_engine.sv
module i2c_sel_engine
  import i2c_chan_sel_pkg::*;
#(
  parameter int HOLD_CYC = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic [ADDR_W-1:0] dev_addr_i,
  input  logic [BYTE_W-1:0] rd_data_i,
  output logic              sda_oe_o,
  output logic              wr_o,
  output logic [BYTE_W-1:0] wr_data_o
);
  localparam int HOLD_W = $clog2(HOLD_CYC + 1);

  eng_state_e        state_q;
  logic              scl_d, sda_d;
  logic [3:0]        cnt_q;
  logic [BYTE_W-1:0] shift_q, tx_q, pend_q;
  logic              pend_vld_q, rw_q, nack_q, drv_q, oe_q;
  logic [HOLD_W-1:0] hold_q;
  logic              scl_rise, scl_fall, start_det, stop_det, byte_done;

  assign scl_rise  = scl_i & ~scl_d;
  assign scl_fall  = ~scl_i & scl_d;
  assign start_det = scl_i & scl_d & ~sda_i & sda_d;
  assign stop_det  = scl_i & scl_d & sda_i & ~sda_d;
  assign byte_done = (cnt_q == 4'd8);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl_i;
      sda_d <= sda_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      cnt_q      <= '0;
      shift_q    <= '0;
      tx_q       <= '0;
      pend_q     <= '0;
      pend_vld_q <= 1'b0;
      rw_q       <= 1'b0;
      nack_q     <= 1'b0;
      drv_q      <= 1'b0;
      oe_q       <= 1'b0;
      hold_q     <= '0;
    end else if (start_det) begin
      state_q <= ST_ADDR;
      cnt_q   <= '0;
      drv_q   <= 1'b0;
      oe_q    <= 1'b0;
      hold_q  <= '0;
    end else if (stop_det) begin
      state_q    <= ST_IDLE;
      pend_vld_q <= 1'b0;
      drv_q      <= 1'b0;
      oe_q       <= 1'b0;
      hold_q     <= '0;
    end else begin
      // SDA only moves once the hold window after SCL fall has run out
      if (hold_q != '0) begin
        hold_q <= hold_q - 1'b1;
        if (hold_q == HOLD_W'(1)) oe_q <= drv_q;
      end
      if (scl_rise) begin
        if (state_q == ST_ADDR || state_q == ST_WDATA || state_q == ST_RDATA) begin
          shift_q <= {shift_q[BYTE_W-2:0], sda_i};
          cnt_q   <= cnt_q + 1'b1;
        end
        if (state_q == ST_RACK) nack_q <= sda_i;
      end
      if (scl_fall) begin
        hold_q <= HOLD_W'(HOLD_CYC);
        case (state_q)
          ST_ADDR: if (byte_done) begin
            if (shift_q[BYTE_W-1:1] == dev_addr_i) begin
              state_q <= ST_ADDR_ACK;
              rw_q    <= shift_q[0];
              drv_q   <= 1'b1;
            end else begin
              state_q <= ST_IDLE;
              drv_q   <= 1'b0;
            end
          end
          ST_ADDR_ACK, ST_RACK: begin
            cnt_q <= '0;
            if (state_q == ST_RACK && nack_q) begin
              state_q <= ST_IDLE;
              drv_q   <= 1'b0;
            end else if (state_q == ST_RACK || rw_q) begin
              state_q <= ST_RDATA;
              drv_q   <= ~rd_data_i[BYTE_W-1];
              tx_q    <= {rd_data_i[BYTE_W-2:0], 1'b0};
            end else begin
              state_q <= ST_WDATA;
              drv_q   <= 1'b0;
            end
          end
          ST_WDATA: if (byte_done) begin
            state_q    <= ST_WACK;
            drv_q      <= 1'b1;
            pend_q     <= shift_q;
            pend_vld_q <= 1'b1;
          end
          ST_WACK: begin
            state_q <= ST_WDATA;
            cnt_q   <= '0;
            drv_q   <= 1'b0;
          end
          ST_RDATA: begin
            if (byte_done) begin
              state_q <= ST_RACK;
              drv_q   <= 1'b0;
            end else begin
              drv_q <= ~tx_q[BYTE_W-1];
              tx_q  <= {tx_q[BYTE_W-2:0], 1'b0};
            end
          end
          default: drv_q <= 1'b0;
        endcase
      end
    end
  end

  assign sda_oe_o  = oe_q;
  assign wr_o      = stop_det & pend_vld_q;
  assign wr_data_o = pend_q;

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE) |-> !sda_oe_o) // R8
    else $error("SDA driven while idle");

  AST_SDA_MOVES_SCL_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((oe_q != $past(oe_q)) && !$past(start_det) && !$past(stop_det)) |-> !scl_i) // R9
    else $error("SDA drive changed while SCL high");

  AST_START_RESYNC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_det |=> (state_q == ST_ADDR && cnt_q == '0 && !sda_oe_o)) // R10
    else $error("START did not resynchronise");
endmodule

// File: rtl/i2c_sel_reg.sv
module i2c_sel_reg #(
  parameter int NUM_CH = 8
) (
  input  logic                clk_i,
  input  logic                por_ni,
  input  logic                bus_rst_ni,
  input  logic                wr_i,
  input  logic [$clog2(NUM_CH):0] wr_data_i,
  output logic [$clog2(NUM_CH):0] sel_o,
  output logic [NUM_CH-1:0]   chan_en_o
);
  localparam int IDX_W = $clog2(NUM_CH);
  localparam int SEL_W = IDX_W + 1;
  localparam logic [SEL_W-1:0] POR_SEL = {1'b1, {IDX_W{1'b0}}};

  logic             rst_n;
  logic [SEL_W-1:0] sel_q;

  assign rst_n = por_ni & bus_rst_ni;

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) sel_q <= por_ni ? '0 : POR_SEL;
    else if (wr_i) sel_q <= wr_data_i;
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : g_dec
    assign chan_en_o[g] = sel_q[IDX_W] && (sel_q[IDX_W-1:0] == IDX_W'(g));
  end

  assign sel_o = sel_q;

  AST_ONE_CHANNEL: assert property (@(posedge clk_i) disable iff (!por_ni)
    $onehot0(chan_en_o)) // R1
    else $error("more than one channel enabled");

  AST_BUS_RST_DROPS: assert property (@(posedge clk_i) disable iff (!por_ni)
    !bus_rst_ni |-> (chan_en_o == '0)) // R3
    else $error("channel left enabled in bus reset");

  AST_COMMIT_AT_STOP: assert property (@(posedge clk_i) disable iff (!rst_n)
    (sel_q != $past(sel_q)) |-> $past(wr_i)) // R7
    else $error("selection changed outside a STOP commit");
endmodule

// File: rtl/i2c_chan_sel.sv
module i2c_chan_sel
  import i2c_chan_sel_pkg::*;
#(
  parameter int          NUM_CH    = 8,
  parameter int          SPIKE_CYC = 4,
  parameter int          HOLD_CYC  = 16,
  parameter logic [3:0]  ADDR_HI   = 4'b1110
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe_o,
  input  logic [2:0]        addr_pins_i,
  output logic [NUM_CH-1:0] chan_en_o
);
  localparam int SEL_W = $clog2(NUM_CH) + 1;

  logic              eng_rst_n;
  logic [1:0]        raw_lines, filt_lines;
  logic              wr;
  logic [BYTE_W-1:0] wr_byte, rd_byte;
  logic [SEL_W-1:0]  sel;
  logic              unused_hi;

  assign eng_rst_n = rst_ni & bus_rst_ni;
  assign raw_lines = {sda_i, scl_i};

  for (genvar l = 0; l < 2; l++) begin : g_filt
    i2c_line_filt #(.SPIKE_CYC(SPIKE_CYC)) u_filt (
      .clk_i  (clk_i),
      .rst_ni (eng_rst_n),
      .line_i (raw_lines[l]),
      .line_o (filt_lines[l])
    );
  end

  i2c_sel_engine #(.HOLD_CYC(HOLD_CYC)) u_engine (
    .clk_i      (clk_i),
    .rst_ni     (eng_rst_n),
    .scl_i      (filt_lines[0]),
    .sda_i      (filt_lines[1]),
    .dev_addr_i ({ADDR_HI, addr_pins_i}),
    .rd_data_i  (rd_byte),
    .sda_oe_o   (sda_oe_o),
    .wr_o       (wr),
    .wr_data_o  (wr_byte)
  );

  i2c_sel_reg #(.NUM_CH(NUM_CH)) u_reg (
    .clk_i      (clk_i),
    .por_ni     (rst_ni),
    .bus_rst_ni (bus_rst_ni),
    .wr_i       (wr),
    .wr_data_i  (wr_byte[SEL_W-1:0]),
    .sel_o      (sel),
    .chan_en_o  (chan_en_o)
  );

  assign rd_byte   = {{(BYTE_W-SEL_W){1'b0}}, sel};
  assign unused_hi = ^wr_byte[BYTE_W-1:SEL_W];
endmodule

// File: tb/i2c_chan_sel_bench.sv
module i2c_chan_sel_bench;
  localparam int CLK_PERIOD = 20;
  localparam int Q          = 20;     // clocks per quarter SCL bit
  localparam int HOLD_CYC   = 16;
  localparam int STOP_LAT   = 7;      // drive of STOP edge to chan_en_o update
  localparam int WATCHDOG   = 150000;
  localparam logic [2:0] PINS = 3'b101;
  localparam logic [6:0] OWN  = {4'b1110, PINS};

  logic clk = 1'b0;
  logic rst_ni = 1'b0, bus_rst_ni = 1'b1;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_oe, sda_bus;
  logic [7:0] chan_en;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  logic [3:0] m_reg = 4'h8, m_pend = 4'h0, m_next = 4'h0;
  bit m_pend_vld = 1'b0;
  int cd = 0;
  int since_fall = 1000;
  logic scl_prev = 1'b1, oe_prev = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign sda_bus = sda_m & ~sda_oe;

  i2c_chan_sel u_i2c_chan_sel (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .bus_rst_ni  (bus_rst_ni),
    .scl_i       (scl_m),
    .sda_i       (sda_bus),
    .sda_oe_o    (sda_oe),
    .addr_pins_i (PINS),
    .chan_en_o   (chan_en)
  );

  function automatic logic [7:0] exp_en(input logic [3:0] r);
    return r[3] ? (8'h01 << r[2:0]) : 8'h00;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // reference model timing and per-clock comparison
  always @(posedge clk) begin
    if (cd > 0) begin
      cd--;
      if (cd == 0) m_reg = m_next;
    end
    #(CLK_PERIOD/4);
    if (rst_ni) begin
      chk(chan_en == exp_en(m_reg), "R1/R7 chan_en vs model", chan_en, exp_en(m_reg));
      if (scl_prev && !scl_m) since_fall = 0; else since_fall++;
      if (sda_oe != oe_prev && bus_rst_ni)
        chk(!scl_m && since_fall >= HOLD_CYC, "R9 hold after SCL fall", since_fall, HOLD_CYC);
    end
    scl_prev = scl_m;
    oe_prev  = sda_oe;
  end

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic i2c_start;
    sda_m = 1'b1; wclk(Q);
    scl_m = 1'b1; wclk(Q);
    sda_m = 1'b0; wclk(Q);
    scl_m = 1'b0; wclk(Q);
  endtask

  task automatic i2c_stop;
    sda_m = 1'b0; wclk(Q);
    scl_m = 1'b1; wclk(Q);
    sda_m = 1'b1;
    if (m_pend_vld) begin
      m_next = m_pend;
      cd = STOP_LAT;
      m_pend_vld = 1'b0;
    end
    wclk(2*Q);
  endtask

  // g: 0 plain, 1 short SCL dip, 2 short SDA pulse, both while SCL high
  task automatic send_bit(input logic b, input int g);
    sda_m = b; wclk(Q);
    scl_m = 1'b1;
    if (g == 0) wclk(2*Q);
    else begin
      wclk(Q/2);
      if (g == 1) scl_m = 1'b0; else sda_m = ~b;
      wclk(3);
      if (g == 1) scl_m = 1'b1; else sda_m = b;
      wclk(2*Q - Q/2 - 3);
    end
    scl_m = 1'b0; wclk(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, input int gbit, input int g, output logic acked);
    for (int i = 7; i >= 0; i--) send_bit(b[i], (i == gbit) ? g : 0);
    sda_m = 1'b1; wclk(Q);
    scl_m = 1'b1; wclk(Q);
    acked = ~sda_bus;
    wclk(Q);
    scl_m = 1'b0; wclk(Q);
  endtask

  task automatic read_byte(input logic nack, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      sda_m = 1'b1; wclk(Q);
      scl_m = 1'b1; wclk(Q);
      b[i] = sda_bus;
      wclk(Q);
      scl_m = 1'b0; wclk(Q);
    end
    sda_m = nack; wclk(Q);
    scl_m = 1'b1; wclk(2*Q);
    scl_m = 1'b0; wclk(Q);
  endtask

  task automatic do_write(input logic [7:0] d, input string req);
    logic a;
    i2c_start;
    send_byte({OWN, 1'b0}, -1, 0, a);
    chk(a, {req, " address ack"}, a, 1);
    send_byte(d, -1, 0, a);
    chk(a, {req, " data ack"}, a, 1);
    m_pend = d[3:0]; m_pend_vld = 1'b1;
    i2c_stop;
    wclk(Q);
  endtask

  task automatic do_read(input int nbytes, input string req);
    logic a;
    logic [7:0] b;
    i2c_start;
    send_byte({OWN, 1'b1}, -1, 0, a);
    chk(a, {req, " read address ack"}, a, 1);
    for (int k = 0; k < nbytes; k++) begin
      read_byte(k == nbytes - 1, b);
      chk(b == {4'h0, m_reg}, {req, " read data"}, b, {4'h0, m_reg});
    end
    wclk(2);
    chk(!sda_oe, "R5 released after NACK", sda_oe, 0);
    i2c_stop;
    wclk(Q);
  endtask

  initial begin
    logic a;
    wclk(5);
    rst_ni = 1'b1;
    wclk(2);
    chk(chan_en == 8'h01, "R2 power-on channel 0", chan_en, 8'h01);
    chk(!sda_oe, "R2 SDA released", sda_oe, 0);
    do_read(1, "R2");

    // R4: select channel 5, then disable
    do_write(8'h0D, "R4");
    chk(chan_en == 8'h20, "R4 channel 5", chan_en, 8'h20);
    do_read(3, "R5");
    do_write(8'h05, "R4");
    chk(chan_en == 8'h00, "R4 enable bit clear", chan_en, 8'h00);

    // R7: multi-byte write keeps last, nothing moves before STOP
    i2c_start;
    send_byte({OWN, 1'b0}, -1, 0, a);
    chk(a, "R7 address ack", a, 1);
    send_byte(8'h0A, -1, 0, a);
    send_byte(8'h0F, -1, 0, a);
    m_pend = 4'hF; m_pend_vld = 1'b1;
    chk(chan_en == 8'h00, "R7 unchanged before STOP", chan_en, 8'h00);
    i2c_stop;
    wclk(Q);
    chk(chan_en == 8'h80, "R7 last byte kept", chan_en, 8'h80);

    // R8: foreign addresses
    i2c_start;
    send_byte({7'h74, 1'b0}, -1, 0, a);
    chk(!a, "R8 no ack for 0x74", a, 0);
    i2c_stop;
    i2c_start;
    send_byte({7'h65, 1'b1}, -1, 0, a);
    chk(!a, "R8 no ack for 0x65", a, 0);
    i2c_stop;
    chk(chan_en == 8'h80, "R8 register untouched", chan_en, 8'h80);

    // R6: short pulses on SCL and SDA inside a data byte
    i2c_start;
    send_byte({OWN, 1'b0}, -1, 0, a);
    send_byte(8'h0E, 2, 1, a);
    chk(a, "R6 ack after SCL glitch", a, 1);
    m_pend = 4'hE; m_pend_vld = 1'b1;
    i2c_stop;
    wclk(Q);
    chk(chan_en == 8'h40, "R6 SCL glitch ignored", chan_en, 8'h40);
    i2c_start;
    send_byte({OWN, 1'b0}, -1, 0, a);
    send_byte(8'h09, 3, 2, a);
    chk(a, "R6 ack after SDA glitch", a, 1);
    m_pend = 4'h9; m_pend_vld = 1'b1;
    i2c_stop;
    wclk(Q);
    chk(chan_en == 8'h02, "R6 SDA glitch ignored", chan_en, 8'h02);

    // R10: STOP in the middle of an address byte
    i2c_start;
    for (int i = 7; i >= 4; i--) send_bit(OWN[i-1], 0);
    i2c_stop;
    do_write(8'h0C, "R10");
    chk(chan_en == 8'h10, "R10 after aborted address", chan_en, 8'h10);

    // R10: repeated START inside a data byte
    i2c_start;
    send_byte({OWN, 1'b0}, -1, 0, a);
    send_bit(1'b0, 0); send_bit(1'b1, 0); send_bit(1'b1, 0);
    i2c_start;
    send_byte({OWN, 1'b0}, -1, 0, a);
    chk(a, "R10 ack after repeated START", a, 1);
    send_byte(8'h0B, -1, 0, a);
    m_pend = 4'hB; m_pend_vld = 1'b1;
    i2c_stop;
    wclk(Q);
    chk(chan_en == 8'h08, "R10 partial byte dropped", chan_en, 8'h08);

    // R3: bus reset while the target holds SDA low for its ack
    i2c_start;
    for (int i = 7; i >= 0; i--) send_bit((i == 0) ? 1'b0 : OWN[i-1], 0);
    sda_m = 1'b1; wclk(2*Q);
    chk(sda_oe, "R3 target driving ack", sda_oe, 1);
    bus_rst_ni = 1'b0;
    m_reg = 4'h0; cd = 0; m_pend_vld = 1'b0;
    #1;
    chk(chan_en == 8'h00, "R3 channels dropped at once", chan_en, 8'h00);
    chk(!sda_oe, "R3 SDA freed at once", sda_oe, 0);
    wclk(5);
    bus_rst_ni = 1'b1;
    wclk(2);
    scl_m = 1'b1; wclk(2*Q);
    do_read(2, "R3");
    do_write(8'h0B, "R3");
    chk(chan_en == 8'h08, "R3 engine usable after reset", chan_en, 8'h08);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=<%0d", WATCHDOG, WATCHDOG);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule